// File: doc/BRIEF.md
# Content-Dependent Variable-Length Redundancy Encoder

This block protects a stream of data words headed for non-volatile storage. For every accepted word it counts the zero bits and picks one of two codes. Cells that hold 0 are the ones most likely to flip, so a word with few zeros gets a single even parity bit. A word with at least a programmable number of zeros gets a 7-bit code: six Hamming check bits plus one overall parity bit, which corrects one error and detects two. The chosen code bits, their length and a select flag come out one cycle after the word is accepted.

A packer appends the variable-length codes, in acceptance order, to a bit stream. It emits the stream as 32-bit signature words, least significant bit first, and a code may straddle two signature words. The block also XORs every accepted data word into a column parity word. A flush request stops intake and drains the packer, padding the last partial signature word with zeros. It then pulses a done flag, and in that cycle the column parity of the finished batch can be read. Storage typically places the column parity word first and the packed signature words after it.

Top module: `vlrc_encoder`

## Requirements
- R1: After reset, in_ready is 1, code_valid, sig_valid and flush_done are 0, col_parity is 0 and the zero threshold is 16.
- R2: A word accepted with fewer zero bits than the threshold yields, on the next cycle, code_valid=1, code_sel=0, code_len=1, code_bits[0] equal to the XOR of all data bits (even parity) and code_bits[6:1]=0.
- R3: A word accepted with a zero count at or above the threshold yields, on the next cycle, code_valid=1, code_sel=1 and code_len=7. Data bit k is placed at the (k+1)-th position, counting from 3 upward, that is not a power of two. code_bits[5:0] is the XOR of the positions of all set data bits. code_bits[6] is the XOR of all data bits and code_bits[5:0].
- R4: With the default threshold, a word with 15 zeros takes parity, a word with 16 zeros takes the 7-bit code, and the all-zero word takes the 7-bit code.
- R5: A write on cfg_thr_we loads cfg_thr_val as the threshold for every word accepted afterwards. A threshold of 0 selects the 7-bit code for every word, and a threshold above 32 selects parity for every word.
- R6: Concatenated over all sig_valid beats (bit 0 of each word first), the signature stream equals the concatenation of the code bits of the accepted words in acceptance order, each code taken from its bit 0 upward.
- R7: After flush_req, remaining code bits are emitted. A final partial word is padded with zeros and carried on sig_valid in the same cycle as a single-cycle flush_done pulse. When the bit count is a multiple of 32, no extra word is emitted.
- R8: In the flush_done cycle, col_parity equals the XOR of all data words accepted since reset or the previous flush. On the next cycle it is 0.
- R9: in_ready is 0 from the cycle after flush_req until the cycle after flush_done, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_thr_we | input | 1 | Load the zero threshold |
| cfg_thr_val | input | ZC_W (6) | New zero threshold |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block accepts a word |
| in_data | input | DATA_W (32) | Data word |
| flush_req | input | 1 | Close the batch and drain the packer |
| code_valid | output | 1 | Code of the previous accepted word is present |
| code_sel | output | 1 | 1: 7-bit code, 0: parity |
| code_len | output | LEN_W (3) | Number of valid code bits (1 or 7) |
| code_bits | output | ECC_W (7) | Code bits, LSB aligned |
| sig_valid | output | 1 | Signature word present |
| sig_word | output | SIG_W (32) | Packed signature word |
| col_parity | output | DATA_W (32) | Running XOR of accepted data words |
| flush_done | output | 1 | Flush finished (one cycle) |

## Verification
A word's code is due one cycle after the clock edge that accepts it, so the bench checks it at the falling edge after that acceptance. The signature stream has no fixed latency, so the bench records every sig_valid beat and compares the whole stream when the batch is flushed. flush_done is awaited with a bounded poll rather than at a fixed cycle. Column parity is checked in the done cycle and its clearing one cycle later, while in_ready is checked one cycle after the request and one cycle after done.

// File: rtl/vlrc_pkg.sv
// Package: width helpers for the variable-length redundancy encoder.
// Assumes: data widths of a few dozen bits; all functions are elaboration-time.
package vlrc_pkg;

    // Number of Hamming check bits r with 2**r >= dw + r + 1.
    function automatic int hamming_chk_w(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Code select values
    typedef enum logic {
        CODE_PARITY = 1'b0,
        CODE_SECDED = 1'b1
    } code_sel_e;

endpackage

// File: rtl/vlrc_code_gen.sv
// Module: vlrc_code_gen
// Counts the zero bits of a data word and builds either an even parity bit or
// a Hamming code with an overall parity bit. Purely combinational.
// Assumes: thr has enough bits to hold DATA_W.
module vlrc_code_gen #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 6,
    parameter int ZC_W   = 6,
    parameter int LEN_W  = 3
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [ZC_W-1:0]    thr,
    output logic               sel,
    output logic [CHK_W:0]     bits,
    output logic [LEN_W-1:0]   len
);
    import vlrc_pkg::*;

    localparam int ECC_W = CHK_W + 1;
    localparam int NPOS  = DATA_W + CHK_W;

    logic [ZC_W-1:0]  zeros;
    logic [CHK_W-1:0] chk;

    // Count zero bits of the word
    always_comb begin
        zeros = '0;
        for (int i = 0; i < DATA_W; i++) zeros = zeros + ZC_W'(!data[i]);
    end

    // Hamming checks: XOR of the codeword positions of the set data bits
    always_comb begin
        int k;
        k   = 0;
        chk = '0;
        for (int p = 1; p <= NPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (data[k]) chk = chk ^ CHK_W'(p);
                k++;
            end
        end
    end

    // Choose the code from the zero count
    always_comb begin
        if (zeros >= thr) begin
            sel  = CODE_SECDED;
            bits = {(^data) ^ (^chk), chk};
            len  = LEN_W'(ECC_W);
        end else begin
            sel  = CODE_PARITY;
            bits = {{CHK_W{1'b0}}, ^data};
            len  = LEN_W'(1);
        end
    end

endmodule

// File: rtl/vlrc_packer.sv
// Module: vlrc_packer
// Appends variable-length codes LSB first into a bit buffer and emits one
// SIG_W-bit word per cycle whenever a full word is held. On flush it emits the
// partial tail padded with zeros and pulses done.
// Assumes: at most one code of up to ECC_W bits arrives per cycle; flush_pend
// stays high until done is seen.
module vlrc_packer #(
    parameter int SIG_W = 32,
    parameter int ECC_W = 7,
    parameter int LEN_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [ECC_W-1:0]   in_bits,
    input  logic [LEN_W-1:0]   in_len,
    input  logic               flush_pend,
    output logic               sig_valid,
    output logic [SIG_W-1:0]   sig_word,
    output logic               done
);
    localparam int BUF_W  = SIG_W + ECC_W;
    localparam int FILL_W = $clog2(BUF_W + 1);

    logic [BUF_W-1:0]  buf_q, buf_d, base_buf, ins;
    logic [FILL_W-1:0] fill_q, fill_d, base_fill;
    logic              full, tail, emit;

    // Next buffer content: drop an emitted word, insert the new code, drain on flush
    always_comb begin
        full      = fill_q >= FILL_W'(SIG_W);
        base_buf  = full ? (buf_q >> SIG_W) : buf_q;
        base_fill = full ? (fill_q - FILL_W'(SIG_W)) : fill_q;
        ins       = in_vld ? (BUF_W'(in_bits) << base_fill) : '0;
        tail      = flush_pend && !in_vld && !full;
        emit      = full || (tail && (fill_q != '0));
        if (tail) begin
            buf_d  = '0;
            fill_d = '0;
        end else begin
            buf_d  = base_buf | ins;
            fill_d = base_fill + (in_vld ? FILL_W'(in_len) : '0);
        end
    end

    // Buffer and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            fill_q <= '0;
        end else begin
            buf_q  <= buf_d;
            fill_q <= fill_d;
        end
    end

    // Output word, its valid and the flush done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_valid <= 1'b0;
            sig_word  <= '0;
            done      <= 1'b0;
        end else begin
            sig_valid <= emit;
            done      <= tail;
            if (emit) sig_word <= buf_q[SIG_W-1:0];
        end
    end

endmodule

// File: rtl/vlrc_encoder.sv
// Module: vlrc_encoder (top)
// Per accepted word: selects parity or a Hamming code by zero count, registers
// the code for one cycle, feeds it to the packer and folds the word into the
// column parity. A flush drains the packer and closes the batch.
// Assumes: cfg writes and data words arrive in separate cycles if the new
// threshold must apply to that word.
module vlrc_encoder #(
    parameter int DATA_W  = 32,
    parameter int SIG_W   = 32,
    parameter int THR_DEF = 16,
    // derived widths, not meant to be overridden
    parameter int ZC_W    = $clog2(DATA_W + 1),
    parameter int ECC_W   = vlrc_pkg::hamming_chk_w(DATA_W) + 1,
    parameter int LEN_W   = $clog2(ECC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_thr_we,
    input  logic [ZC_W-1:0]   cfg_thr_val,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              flush_req,
    output logic              code_valid,
    output logic              code_sel,
    output logic [LEN_W-1:0]  code_len,
    output logic [ECC_W-1:0]  code_bits,
    output logic              sig_valid,
    output logic [SIG_W-1:0]  sig_word,
    output logic [DATA_W-1:0] col_parity,
    output logic              flush_done
);
    localparam int CHK_W = ECC_W - 1;

    logic [ZC_W-1:0]  thr_q;
    logic             flushing_q;
    logic             accept;
    logic             gen_sel;
    logic [ECC_W-1:0] gen_bits;
    logic [LEN_W-1:0] gen_len;

    assign in_ready = !flushing_q;
    assign accept   = in_valid && in_ready;

    vlrc_code_gen #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .ZC_W   (ZC_W),
        .LEN_W  (LEN_W)
    ) gen_i (
        .data (in_data),
        .thr  (thr_q),
        .sel  (gen_sel),
        .bits (gen_bits),
        .len  (gen_len)
    );

    // Programmable zero threshold
    always_ff @(posedge clk) begin
        if (!rst_n)          thr_q <= ZC_W'(THR_DEF);
        else if (cfg_thr_we) thr_q <= cfg_thr_val;
    end

    // One-cycle code stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            code_sel   <= 1'b0;
            code_len   <= '0;
            code_bits  <= '0;
        end else begin
            code_valid <= accept;
            if (accept) begin
                code_sel  <= gen_sel;
                code_len  <= gen_len;
                code_bits <= gen_bits;
            end
        end
    end

    // Column parity of the batch, cleared after the done cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          col_parity <= '0;
        else if (flush_done) col_parity <= '0;
        else if (accept)     col_parity <= col_parity ^ in_data;
    end

    // Flush state: set by request, cleared after done
    always_ff @(posedge clk) begin
        if (!rst_n)          flushing_q <= 1'b0;
        else if (flush_done) flushing_q <= 1'b0;
        else if (flush_req)  flushing_q <= 1'b1;
    end

    vlrc_packer #(
        .SIG_W (SIG_W),
        .ECC_W (ECC_W),
        .LEN_W (LEN_W)
    ) pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (code_valid),
        .in_bits    (code_bits),
        .in_len     (code_len),
        .flush_pend (flushing_q && !flush_done),
        .sig_valid  (sig_valid),
        .sig_word   (sig_word),
        .done       (flush_done)
    );

endmodule

// File: rtl/vlrc_encoder_chk.sv
// Module: vlrc_encoder_chk
// Protocol and code-shape properties of vlrc_encoder, bound to every instance.
module vlrc_encoder_chk #(
    parameter int DATA_W = 32,
    parameter int ECC_W  = 7,
    parameter int LEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              flush_req,
    input logic              code_valid,
    input logic              code_sel,
    input logic [LEN_W-1:0]  code_len,
    input logic [ECC_W-1:0]  code_bits,
    input logic              flush_done,
    input logic [DATA_W-1:0] col_parity
);
    AST_CODE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> code_valid); // R2
    AST_NO_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !code_valid); // R3
    AST_PARITY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !code_sel) |-> (code_len == LEN_W'(1) && code_bits[ECC_W-1:1] == '0)); // R2
    AST_SECDED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_sel) |-> code_len == LEN_W'(ECC_W)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done); // R7
    AST_COL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> col_parity == '0); // R8
    AST_READY_LOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !in_ready); // R9
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> !in_ready); // R9
endmodule

bind vlrc_encoder vlrc_encoder_chk #(
    .DATA_W (DATA_W),
    .ECC_W  (ECC_W),
    .LEN_W  (LEN_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .flush_req  (flush_req),
    .code_valid (code_valid),
    .code_sel   (code_sel),
    .code_len   (code_len),
    .code_bits  (code_bits),
    .flush_done (flush_done),
    .col_parity (col_parity)
);

// File: tb/vlrc_encoder_tb_top.sv
module vlrc_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_thr_we = 1'b0;
    logic [5:0]  cfg_thr_val = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        flush_req = 1'b0;
    logic        code_valid, code_sel, sig_valid, flush_done;
    logic [2:0]  code_len;
    logic [6:0]  code_bits;
    logic [31:0] sig_word, col_parity;

    int          n_run = 0;
    int          n_fail = 0;
    int          cur_thr = 16;
    logic [31:0] col_m = '0;
    logic [31:0] lf = 32'h1234_5678;
    bit          exp_q[$];
    bit          act_q[$];

    always #2 clk = ~clk;

    vlrc_encoder dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_thr_we (cfg_thr_we), .cfg_thr_val (cfg_thr_val),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data), .flush_req (flush_req),
        .code_valid (code_valid), .code_sel (code_sel), .code_len (code_len), .code_bits (code_bits),
        .sig_valid (sig_valid), .sig_word (sig_word), .col_parity (col_parity), .flush_done (flush_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected 7-bit code: checks are the XOR of data-bit positions
    function automatic logic [6:0] ham(input logic [31:0] d);
        logic [5:0] c;
        int pos;
        c = '0;
        pos = 2;
        for (int k = 0; k < 32; k++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            if (d[k]) c = c ^ 6'(pos);
        end
        return {(^d) ^ (^c), c};
    endfunction

    // Record the signature stream
    always @(negedge clk) begin
        if (rst_n && sig_valid)
            for (int b = 0; b < 32; b++) act_q.push_back(sig_word[b]);
    end

    task automatic check_code(input logic [31:0] d);
        int z;
        z = $countones(~d);
        chk(code_valid == 1'b1, "R2 code_valid", code_valid, 1);
        if (z >= cur_thr) begin
            chk(code_sel == 1'b1 && code_len == 3'd7, (cur_thr == 16) ? "R3 R4 ecc select" : "R3 R5 ecc select",
                {code_sel, code_len}, {1'b1, 3'd7});
            chk(code_bits == ham(d), "R3 ecc bits", code_bits, ham(d));
        end else begin
            chk(code_sel == 1'b0 && code_len == 3'd1, (cur_thr == 16) ? "R2 R4 parity select" : "R2 R5 parity select",
                {code_sel, code_len}, {1'b0, 3'd1});
            chk(code_bits == {6'b0, ^d}, "R2 parity bits", code_bits, {6'b0, ^d});
        end
    endtask

    // Send n words back to back; mode 0: zero-count sweep, 1: pseudo-random, 2: all ones
    task automatic send_burst(input int n, input int mode);
        logic [31:0] d, prev, mask;
        d = '0;
        prev = '0;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) check_code(prev);
            if (i < n) begin
                if (mode == 0) begin
                    mask = (i >= 32) ? 32'hFFFF_FFFF : ((32'h1 << i) - 32'h1);
                    d = ~mask;
                    d = (d << (i % 7)) | (d >> (32 - (i % 7)));
                    if (i % 7 == 0) d = ~mask;
                end else if (mode == 1) begin
                    lf = lf ^ (lf << 13);
                    lf = lf ^ (lf >> 17);
                    lf = lf ^ (lf << 5);
                    d = lf;
                end else begin
                    d = 32'hFFFF_FFFF;
                end
                in_valid = 1'b1;
                in_data = d;
                prev = d;
                col_m = col_m ^ d;
                if ($countones(~d) >= cur_thr) begin
                    logic [6:0] h;
                    h = ham(d);
                    for (int b = 0; b < 7; b++) exp_q.push_back(h[b]);
                end else begin
                    exp_q.push_back(^d);
                end
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic set_thr(input int t);
        @(negedge clk);
        cfg_thr_we = 1'b1;
        cfg_thr_val = 6'(t);
        @(negedge clk);
        cfg_thr_we = 1'b0;
        cur_thr = t;
    endtask

    task automatic do_flush();
        int w, exp_n, mism;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        chk(in_ready == 1'b0, "R9 ready low after flush request", in_ready, 0);
        w = 0;
        while (!flush_done && w < 60) begin
            @(negedge clk);
            w++;
        end
        chk(flush_done == 1'b1, "R7 flush_done seen", flush_done, 1);
        #1;
        exp_n = ((exp_q.size() + 31) / 32) * 32;
        while (exp_q.size() < exp_n) exp_q.push_back(1'b0);
        chk(act_q.size() == exp_n, "R7 stream length with padding", act_q.size(), exp_n);
        mism = 0;
        for (int i = 0; i < exp_n && i < act_q.size(); i++) if (act_q[i] != exp_q[i]) mism++;
        chk(mism == 0, "R6 packed stream bits", mism, 0);
        chk(col_parity == col_m, "R8 column parity at done", col_parity, col_m);
        @(negedge clk);
        chk(col_parity == 32'h0, "R8 column parity cleared", col_parity, 0);
        chk(in_ready == 1'b1, "R9 ready back after done", in_ready, 1);
        chk(flush_done == 1'b0, "R7 done is one cycle", flush_done, 0);
        exp_q.delete();
        act_q.delete();
        col_m = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk({code_valid, sig_valid, flush_done} == 3'b000, "R1 valids low", {code_valid, sig_valid, flush_done}, 0);
        chk(col_parity == 32'h0, "R1 col_parity", col_parity, 0);

        send_burst(33, 0);      // default threshold sweep, R4
        do_flush();
        set_thr(0);             // R5 all words take the 7-bit code
        send_burst(40, 1);
        do_flush();
        set_thr(33);            // R5 all words take parity
        send_burst(33, 0);
        do_flush();
        send_burst(32, 2);      // exactly 32 bits, no pad word (R7)
        do_flush();
        set_thr(20);
        send_burst(60, 1);
        do_flush();
        do_flush();             // empty batch
        set_thr(16);
        send_burst(150, 1);
        do_flush();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule